// File: doc/BRIEF.md
# Nine-Level Pulse-Frame Encoder

This block sits behind the quantizer of a multilevel sigma-delta loop. Each quantizer decision is a level from 0 to 8: the number of ones to send within the next eight master-clock cycles. The block turns that level into an 8-bit pulse pattern and shifts it out one bit per clock. The result is a pulse-width-modulated stream at the master-clock rate whose local density of ones follows the loop output.

Three static control pins shape the pattern. The first is a mute that forces the zero-signal density. The second is an active-low restriction that drops the all-zeros and all-ones levels and leaves seven. The third enables rotation, which starts the pulse at a pseudo-random position in each frame. With rotation off and the restriction active, every frame carries at least one rising and one falling edge. The transition density then stays the same for every signal, which suits a FIR-type DAC whose length is a multiple of eight taps.

Levels arrive on a valid/ready stream, and ready is the only back-pressure. Ready is high for one cycle in eight, on the last cycle of each frame. The producer holds valid and the level until it sees a cycle with both high; only that cycle transfers a level. If valid is low at a frame boundary, no level is taken and the last accepted level is sent again. The stream never stalls the serial output.

Top module: `pwm8_encoder`

## Requirements
- R1: During and right after reset, in_ready is 1 and bit_out is 1. The held level is the mid level 4, so a frame started with no valid transfer carries four ones.
- R2: in_ready is high for exactly one cycle in every eight. A level is taken only in a cycle with in_valid and in_ready both high, and valid raised while ready is low changes nothing.
- R3: With rotation off, an effective level k produces k ones followed by 8-k zeros. Bit 7 (the first one) appears on bit_out in the cycle after the transfer, and bit 0 appears seven cycles later.
- R4: Input levels above 8 (in_level 9 to 15) are treated as level 8.
- R5: With inner_n at 0, level 0 is sent as level 1 and level 8 is sent as level 7. Other levels are unchanged.
- R6: With inner_n at 0 and rot_en at 0, every frame holds at least one 1 and at least one 0.
- R7: With rot_en at 1, each frame is the R3 pattern rotated by an offset from 0 to 7 taken from a maximal-length LFSR that advances once per frame. The count of ones is unchanged, the ones stay one circular run, and the position varies from frame to frame.
- R8: With mute at 1, the frame holds four ones, whatever the input level. A level offered during mute is still taken and becomes the held level.
- R9: A frame boundary with no valid transfer repeats the last accepted level under the control pins present at that boundary.
- R10: The control pins are sampled only at the frame boundary. Changing them in the middle of a frame does not alter the frame being sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock, one output bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A level is offered |
| in_ready | output | 1 | Frame boundary: a level can be taken this cycle |
| in_level | input | 4 | Requested count of ones per frame (0 to 8; higher values clamp) |
| mute | input | 1 | Active high: send the mid level |
| inner_n | input | 1 | Active low: allow only levels 1 to 7 |
| rot_en | input | 1 | Active high: rotate the pattern by a pseudo-random offset |
| bit_out | output | 1 | Serial pulse stream, MSB of each frame first |

## Verification
The bench first sends every level from 0 to 8 with rotation off. An exact match against a left-aligned run of ones separates off-by-one errors in level, bit order and frame alignment. Out-of-range levels and the boundary levels under restriction show whether clamping happens and whether the seven-level mode maps 0 and 8 to 1 and 7. Muted, underrun and stray-valid frames show whether a level is taken, held or ignored. Control pins toggled in mid-frame show whether the controls are sampled at the boundary. Rotated frames are checked for their count of ones, for a single circular run and for variety of position, which shows that rotation happens without modelling the LFSR.

// File: rtl/pwm8_pkg.sv
package pwm8_pkg;

  localparam int DEF_FRAME_LEN = 8;
  localparam int DEF_LFSR_W    = 8;

  // Control pins, captured together at each frame boundary.
  typedef struct packed {
    logic mute;
    logic inner_n;
    logic rot_en;
  } pwm8_ctl_t;

  function automatic int mid_level(input int frame_len);
    return frame_len / 2;
  endfunction

endpackage

// File: rtl/pwm8_lfsr.sv
module pwm8_lfsr #(
  parameter int              LFSR_W = 8,
  parameter logic [LFSR_W-1:0] TAPS = 8'hB8,
  parameter logic [LFSR_W-1:0] SEED = 8'h01,
  parameter int              OFS_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  output logic [OFS_W-1:0] offset
);

  logic [LFSR_W-1:0] state_q;
  logic [LFSR_W-1:0] state_d;

  // Galois form, shifting right; the tap mask is applied when bit 0 is set.
  always_comb begin
    state_d = state_q >> 1;
    if (state_q[0]) state_d = state_d ^ TAPS;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       state_q <= SEED;
    else if (advance) state_q <= state_d;
  end

  assign offset = state_q[OFS_W-1:0];

endmodule

// File: rtl/pwm8_level_shaper.sv
module pwm8_level_shaper
  import pwm8_pkg::*;
#(
  parameter int FRAME_LEN = 8,
  parameter int LVL_W     = 4
) (
  input  logic [LVL_W-1:0] level_in,
  input  pwm8_ctl_t        ctl,
  output logic [LVL_W-1:0] level_out
);

  localparam logic [LVL_W-1:0] LV_MAX = LVL_W'(FRAME_LEN);
  localparam logic [LVL_W-1:0] LV_MID = LVL_W'(mid_level(FRAME_LEN));
  localparam logic [LVL_W-1:0] LV_TOP = LVL_W'(FRAME_LEN - 1);
  localparam logic [LVL_W-1:0] LV_ONE = LVL_W'(1);

  logic [LVL_W-1:0] clamped;

  always_comb begin
    clamped = (level_in > LV_MAX) ? LV_MAX : level_in;
    if (ctl.mute) begin
      level_out = LV_MID;
    end else if (!ctl.inner_n && clamped == '0) begin
      level_out = LV_ONE;
    end else if (!ctl.inner_n && clamped == LV_MAX) begin
      level_out = LV_TOP;
    end else begin
      level_out = clamped;
    end
  end

endmodule

// File: rtl/pwm8_pattern_gen.sv
module pwm8_pattern_gen #(
  parameter int FRAME_LEN = 8,
  parameter int LVL_W     = 4,
  parameter int OFS_W     = 3
) (
  input  logic [LVL_W-1:0]     level,
  input  logic                 rot_en,
  input  logic [OFS_W-1:0]     offset,
  output logic [FRAME_LEN-1:0] pattern
);

  logic [FRAME_LEN-1:0]   base;
  logic [2*FRAME_LEN-1:0] doubled;
  logic [OFS_W-1:0]       shift;

  // Left-aligned run of ones: bit (FRAME_LEN-1-i) is set when level > i.
  for (genvar i = 0; i < FRAME_LEN; i++) begin : g_thermo
    assign base[FRAME_LEN-1-i] = (level > LVL_W'(i));
  end

  assign shift   = rot_en ? offset : '0;
  assign doubled = {base, base};
  assign pattern = doubled[shift +: FRAME_LEN];

endmodule

// File: rtl/pwm8_serializer.sv
module pwm8_serializer #(
  parameter int                   FRAME_LEN = 8,
  parameter int                   CNT_W     = 3,
  parameter logic [FRAME_LEN-1:0] RESET_PAT = 8'hF0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [FRAME_LEN-1:0] pattern,
  output logic                 frame_last,
  output logic [FRAME_LEN-1:0] frame_q,
  output logic                 bit_out
);

  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_LEN - 1);

  logic [CNT_W-1:0] cnt_q;

  assign frame_last = (cnt_q == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= CNT_LAST;
      frame_q <= RESET_PAT;
    end else if (frame_last) begin
      cnt_q   <= '0;
      frame_q <= pattern;
    end else begin
      cnt_q   <= cnt_q + 1'b1;
      frame_q <= frame_q << 1;
    end
  end

  assign bit_out = frame_q[FRAME_LEN-1];

endmodule

// File: rtl/pwm8_encoder.sv
module pwm8_encoder
  import pwm8_pkg::*;
#(
  parameter int FRAME_LEN = DEF_FRAME_LEN,
  parameter int LFSR_W    = DEF_LFSR_W,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 8'hB8,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 8'h01,
  localparam int LVL_W = $clog2(FRAME_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [LVL_W-1:0] in_level,
  input  logic             mute,
  input  logic             inner_n,
  input  logic             rot_en,
  output logic             bit_out
);

  localparam int OFS_W = $clog2(FRAME_LEN);
  localparam int MID   = mid_level(FRAME_LEN);
  localparam logic [LVL_W-1:0]     LV_MID    = LVL_W'(MID);
  localparam logic [FRAME_LEN-1:0] RESET_PAT = ~({FRAME_LEN{1'b1}} >> MID);

  pwm8_ctl_t            ctl;
  logic                 frame_last;
  logic                 accept;
  logic [LVL_W-1:0]     held_q;
  logic [LVL_W-1:0]     sel_level;
  logic [LVL_W-1:0]     eff_level;
  logic [OFS_W-1:0]     offset;
  logic [FRAME_LEN-1:0] pattern;
  logic [FRAME_LEN-1:0] frame_q;

  assign ctl       = '{mute: mute, inner_n: inner_n, rot_en: rot_en};
  assign in_ready  = frame_last;
  assign accept    = in_valid & frame_last;
  assign sel_level = accept ? in_level : held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      held_q <= LV_MID;
    else if (accept) held_q <= in_level;
  end

  pwm8_level_shaper #(.FRAME_LEN(FRAME_LEN), .LVL_W(LVL_W)) u_shape (
    .level_in (sel_level),
    .ctl      (ctl),
    .level_out(eff_level)
  );

  pwm8_lfsr #(.LFSR_W(LFSR_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED), .OFS_W(OFS_W)) u_lfsr (
    .clk    (clk),
    .rst_n  (rst_n),
    .advance(frame_last),
    .offset (offset)
  );

  pwm8_pattern_gen #(.FRAME_LEN(FRAME_LEN), .LVL_W(LVL_W), .OFS_W(OFS_W)) u_pat (
    .level  (eff_level),
    .rot_en (ctl.rot_en),
    .offset (offset),
    .pattern(pattern)
  );

  pwm8_serializer #(.FRAME_LEN(FRAME_LEN), .CNT_W(OFS_W), .RESET_PAT(RESET_PAT)) u_ser (
    .clk       (clk),
    .rst_n     (rst_n),
    .pattern   (pattern),
    .frame_last(frame_last),
    .frame_q   (frame_q),
    .bit_out   (bit_out)
  );

endmodule

// File: rtl/pwm8_encoder_chk.sv
module pwm8_encoder_chk #(
  parameter int FRAME_LEN = 8,
  localparam int LVL_W = $clog2(FRAME_LEN + 1)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic [LVL_W-1:0]     in_level,
  input logic                 mute,
  input logic                 inner_n,
  input logic                 rot_en,
  input logic [FRAME_LEN-1:0] frame_q,
  input logic [LVL_W-1:0]     held_q
);

  localparam int GAP_W = $clog2(FRAME_LEN);
  localparam logic [GAP_W-1:0]     GAP_END = GAP_W'(FRAME_LEN - 1);
  localparam logic [FRAME_LEN-1:0] ONE     = FRAME_LEN'(1);
  localparam logic [LVL_W-1:0]     LV_MAX  = LVL_W'(FRAME_LEN);

  logic [GAP_W-1:0]     gap_q;
  logic [FRAME_LEN-1:0] inv_q;
  logic                 left_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        gap_q <= GAP_END;
    else if (in_ready) gap_q <= '0;
    else               gap_q <= gap_q + 1'b1;
  end

  assign inv_q    = ~frame_q;
  assign left_run = ((inv_q & (inv_q + ONE)) == '0);

  AST_READY_CADENCE: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready == (gap_q == GAP_END)); // R2

  AST_NO_TAKE_WITHOUT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> $stable(held_q)); // R2

  AST_PLAIN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready && !rot_en |=> left_run); // R3

  AST_CLAMP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready && in_valid && in_level > LV_MAX && !mute |=>
      $countones(frame_q) == (inner_n ? FRAME_LEN : FRAME_LEN - 1)); // R4

  AST_INNER_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready && !inner_n |=> (frame_q != '0) && (frame_q != '1)); // R5

  AST_MUTE_MID: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready && mute |=> $countones(frame_q) == FRAME_LEN / 2); // R8

endmodule

bind pwm8_encoder pwm8_encoder_chk #(.FRAME_LEN(FRAME_LEN)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .in_valid(in_valid),
  .in_ready(in_ready),
  .in_level(in_level),
  .mute    (mute),
  .inner_n (inner_n),
  .rot_en  (rot_en),
  .frame_q (frame_q),
  .held_q  (held_q)
);

// File: tb/sim_pwm8_encoder.sv
`timescale 1ns/1ps
module sim_pwm8_encoder;

  typedef struct {
    int    k;
    bit    rot;
    bit    mix;
    string tag;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [3:0] in_level = 4'd0;
  logic       mute = 1'b0;
  logic       inner_n = 1'b1;
  logic       rot_en = 1'b0;
  logic       bit_out;

  int     n_checks = 0;
  int     n_fail = 0;
  item_t  sb[$];
  item_t  cur;
  int     col = 0;
  bit [7:0] got;
  bit     draining = 0;
  bit     done = 0;
  int     held = 4;
  bit [255:0] seen_rot;
  int     gap = 0;
  bit     gap_on = 0;
  int     gap_bad = 0;

  always #10 clk = ~clk;

  pwm8_encoder u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_level(in_level), .mute(mute), .inner_n(inner_n), .rot_en(rot_en),
    .bit_out(bit_out)
  );

  task automatic check(input bit ok, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic int model_k(input int lvl, input bit m, input bit inr_n);
    int k;
    if (m) return 4;
    k = (lvl > 8) ? 8 : lvl;
    if (!inr_n && k == 0) k = 1;
    if (!inr_n && k == 8) k = 7;
    return k;
  endfunction

  function automatic int circ_runs(input bit [7:0] p);
    int r = 0;
    for (int i = 0; i < 8; i++) if (p[i] && !p[(i + 1) % 8]) r++;
    return r;
  endfunction

  task automatic compare(input item_t it, input bit [7:0] p);
    bit [7:0] exp_p;
    check($countones(p) == it.k, {it.tag, " ones per frame"}, $countones(p), it.k);
    if (!it.rot) begin
      exp_p = ~(8'hFF >> it.k);
      check(p == exp_p, {it.tag, " exact pattern"}, p, exp_p);
    end else begin
      check(circ_runs(p) <= 1, {it.tag, " single circular run"}, circ_runs(p), 1);
      if (it.k == 3) seen_rot[p] = 1'b1;
    end
    if (it.mix) check(p != 8'h00 && p != 8'hFF, {it.tag, " R6 mixed frame"}, p, 8'h55);
  endtask

  // Monitor: frames start at each ready cycle; bits arrive on the next 8 samples.
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      if (gap_on) begin
        gap++;
        if (in_ready) begin
          if (gap != 8) gap_bad++;
          gap = 0;
        end
      end else if (in_ready) begin
        gap_on = 1;
        gap = 0;
      end
      if (col > 0) begin
        got = {got[6:0], bit_out};
        col--;
        if (col == 0) compare(cur, got);
      end
      if (in_ready) begin
        if (sb.size() > 0) begin
          cur = sb.pop_front();
          col = 8;
        end else if (!draining) begin
          check(0, "R2 scoreboard empty at boundary", 0, 1);
        end
      end
    end
  end

  // Driver: present one frame's stimulus at the next boundary.
  task automatic send(input int lvl, input bit vld, input bit m, input bit inr_n,
                      input bit r, input bit glitch, input string tag);
    item_t it;
    while (!in_ready) @(negedge clk);
    in_valid = vld;
    in_level = 4'(lvl);
    mute     = m;
    inner_n  = inr_n;
    rot_en   = r;
    if (vld) held = lvl;
    it.k   = model_k(held, m, inr_n);
    it.rot = r;
    it.mix = !inr_n && !r;
    it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
    in_valid = 1'b0;
    if (glitch) begin
      mute = ~m; inner_n = ~inr_n; rot_en = ~r;
      repeat (3) @(negedge clk);
      mute = m; inner_n = inr_n; rot_en = r;
    end
  endtask

  initial begin
    #(20 * 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    seen_rot = '0;
    repeat (3) @(negedge clk);
    check(in_ready == 1'b1, "R1 ready in reset", in_ready, 1);
    check(bit_out == 1'b1, "R1 bit_out in reset", bit_out, 1);
    rst_n = 1'b1;

    send(0, 0, 0, 1, 0, 0, "R1 mid level after reset");
    for (int l = 0; l <= 8; l++) send(l, 1, 0, 1, 0, 0, "R3 level sweep");
    send(9, 1, 0, 1, 0, 0, "R4 clamp 9");
    send(15, 1, 0, 1, 0, 0, "R4 clamp 15");
    send(15, 1, 0, 0, 0, 0, "R4 R5 clamp under restriction");
    send(0, 1, 0, 0, 0, 0, "R5 low edge");
    send(8, 1, 0, 0, 0, 0, "R5 high edge");
    send(1, 1, 0, 0, 0, 0, "R5 level 1");
    send(7, 1, 0, 0, 0, 0, "R5 level 7");
    send(4, 1, 0, 0, 0, 0, "R6 level 4");
    send(0, 1, 1, 1, 0, 0, "R8 mute 0");
    send(15, 1, 1, 1, 0, 0, "R8 mute 15");
    send(0, 0, 0, 1, 0, 0, "R8 R9 muted level was held");
    send(2, 1, 0, 1, 0, 0, "R9 load 2");
    send(0, 0, 0, 1, 0, 0, "R9 repeat 1");
    send(0, 0, 0, 0, 0, 0, "R9 repeat under new controls");
    send(5, 1, 0, 1, 0, 0, "R2 load 5");
    in_valid = 1'b1; in_level = 4'd0;
    repeat (3) @(negedge clk);
    in_valid = 1'b0;
    send(0, 0, 0, 1, 0, 0, "R2 stray valid ignored");
    send(6, 1, 0, 1, 0, 1, "R10 mid-frame toggles");
    send(8, 1, 0, 0, 0, 1, "R10 mid-frame toggles restricted");
    for (int f = 0; f < 32; f++) send(3, 1, 0, 1, 1, 0, "R7 rotated level 3");
    send(6, 1, 0, 1, 1, 0, "R7 rotated level 6");
    send(9, 1, 1, 1, 1, 0, "R7 R8 rotated mute");
    send(0, 1, 0, 0, 1, 0, "R7 R5 rotated restricted");
    draining = 1;
    repeat (12) @(negedge clk);
    done = 1;
    check($countones(seen_rot) >= 4, "R7 distinct rotations", $countones(seen_rot), 4);
    check(gap_bad == 0, "R2 ready every 8 cycles", gap_bad, 0);
    check(sb.size() == 0, "R3 all frames observed", sb.size(), 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule